// File: doc/BRIEF.md
# Cascaded Serial-to-Parallel Word Assembler

This block turns a one-bit serial stream into parallel words. Each rising edge of the serial clock captures one bit, least significant bit first. The block holds a chain of slices that are built inside it and share the same serial line. Each slice collects up to nine bits. When one slice has its share of the word, its end-of-slice marker hands capture to the next slice. When the last slice finishes, the complete word goes out on a single-cycle write request to a storage array outside the block.

Each slice has two marker outputs. One rises when the slice takes its eighth bit and one rises when it takes its ninth bit. A word-length select chooses which marker closes a slice, and so also the whole word. The selected marker of the last slice means the word is done, and the next rising edge starts a new word. A full indication from the storage side blocks the write of a word that completes while it is high, and that word is lost. An enable input gates the first slice, so a slice chain can also be extended from outside.

Top module: `ser_word_asm`

## Requirements
- R1: Bits are captured least significant first. Serial bit i of a word lands in slice i/W at bit position i mod W of that slice, where W is 8 or 9. Slice k occupies bits [9k+8:9k] of the output word.
- R2: While synchronous reset is high, and on the cycle after it, every marker output and the write request are low.
- R3: On the first rising edge of each new word, every marker output of every slice goes low.
- R4: A slice's bit-8 marker goes high on the edge that captures its eighth bit (position 7). Its bit-9 marker goes high on the edge that captures its ninth bit (position 8). Each marker stays high until the next word starts.
- R5: With `len_sel`=0 each slice takes 8 bits, the bit-8 marker closes it, and bit 8 of each slice in the output word is 0. With `len_sel`=1 each slice takes 9 bits and the bit-9 marker closes it.
- R6: Slice k>0 captures its first bit on the edge after the closing marker of slice k-1 goes high. Slice 0 captures only while `cas_in` is high. Slices fill strictly in order, from least to most significant.
- R7: `wr_req_o` is high for exactly one cycle. That cycle begins at the edge that captures the last bit of the word, and `wr_data_o` carries the whole word during it.
- R8: If `full_in` is high at the edge that completes a word, no write request is issued and that word is discarded. The following word is assembled and written normally.
- R9: While `cas_in` is low and slice 0 is waiting to start, serial bits are ignored. No marker rises and none of those bits appears in a later word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial clock; every rising edge takes one bit |
| rst | input | 1 | Synchronous reset, active high |
| ser_in | input | 1 | Serial data bit |
| cas_in | input | 1 | Capture enable for slice 0 (tie high when standalone) |
| len_sel | input | 1 | Slice length: 0 = 8 bits, 1 = 9 bits |
| full_in | input | 1 | Storage full; suppresses the write of a completing word |
| tap8_o | output | SLICES | Bit-8 marker of each slice |
| tap9_o | output | SLICES | Bit-9 marker of each slice |
| wr_req_o | output | 1 | Single-cycle write request |
| wr_data_o | output | 9*SLICES | Assembled word, 9 bits per slice |

## Verification
Every result is one register stage behind the edge that caused it. A marker is visible right after the edge that captures position 7 or 8. The write request and its data are visible right after the edge that takes the last serial bit of the word, and the request is gone after the next edge, which also clears all markers. The bench drives each bit a few nanoseconds after a rising edge and reads the outputs a few nanoseconds after the following edge. Each check therefore looks at exactly the register state produced by the bit just sent. The expected word is built from the serial stream by the slice and position rule in R1 and R5.

// File: rtl/ser_asm_pkg.sv
package ser_asm_pkg;

    // Storage width of one slice
    localparam int SLICE_W  = 9;
    localparam int CNT_W    = 4;

    typedef logic [SLICE_W-1:0] slice_word_t;
    typedef logic [CNT_W-1:0]   bit_pos_t;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,   // waiting for capture enable
        PH_SHIFT = 2'd1,   // collecting bits
        PH_HOLD  = 2'd2    // slice complete, waiting for word restart
    } slice_phase_e;

    // Position of the bit that closes a slice
    function automatic bit_pos_t close_pos(input logic nine_bit);
        return nine_bit ? bit_pos_t'(8) : bit_pos_t'(7);
    endfunction

    // Position of the bit-8 and bit-9 markers
    localparam bit_pos_t TAP8_POS = bit_pos_t'(7);
    localparam bit_pos_t TAP9_POS = bit_pos_t'(8);

endpackage

// File: rtl/ser_slice.sv
module ser_slice
    import ser_asm_pkg::*;
#(
    parameter bit FIRST = 1'b0
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        ser_in,
    input  logic        cas_en,
    input  logic        len_sel,
    input  logic        restart,
    output logic        tap8,
    output logic        tap9,
    output logic        tap_sel,
    output logic        done_now,
    output slice_word_t word_nxt
);

    slice_phase_e phase_q;
    bit_pos_t     cnt_q;
    slice_word_t  word_q;
    logic         tap8_q;
    logic         tap9_q;

    logic     start;
    logic     capture;
    bit_pos_t pos;

    // A restart edge begins a new word: only the first slice may start on it
    always_comb begin
        if (restart) begin
            start = FIRST && cas_en;
        end else begin
            start = (phase_q == PH_IDLE) && cas_en;
        end
        capture = start || ((phase_q == PH_SHIFT) && !restart);
        pos     = start ? '0 : cnt_q;
    end

    always_comb begin
        word_nxt = start ? '0 : word_q;
        if (capture) begin
            word_nxt[pos] = ser_in;
        end
        done_now = capture && (pos == close_pos(len_sel));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
            word_q  <= '0;
            tap8_q  <= 1'b0;
            tap9_q  <= 1'b0;
        end else begin
            if (restart) begin
                tap8_q <= 1'b0;
                tap9_q <= 1'b0;
            end
            if (capture) begin
                word_q  <= word_nxt;
                cnt_q   <= pos + bit_pos_t'(1);
                phase_q <= done_now ? PH_HOLD : PH_SHIFT;
                if (pos == TAP8_POS) tap8_q <= 1'b1;
                if (pos == TAP9_POS) tap9_q <= 1'b1;
            end else if (restart) begin
                phase_q <= PH_IDLE;
                cnt_q   <= '0;
            end
        end
    end

    assign tap8    = tap8_q;
    assign tap9    = tap9_q;
    assign tap_sel = len_sel ? tap9_q : tap8_q;

    // R4: the bit-9 marker only rises once the bit-8 marker is already up
    assert_tap_order_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(tap9_q) |-> tap8_q);

    // R3: a restart edge leaves both markers low
    assert_restart_clears_R3: assert property (@(posedge clk) disable iff (rst)
        restart |=> (!tap8_q && !tap9_q));

endmodule

// File: rtl/ser_wr_port.sv
module ser_wr_port
    import ser_asm_pkg::*;
#(
    parameter int SLICES = 2
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        word_done,
    input  logic                        full_in,
    input  logic [SLICES*SLICE_W-1:0]   word_in,
    output logic                        wr_req,
    output logic [SLICES*SLICE_W-1:0]   wr_data
);

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_req  <= 1'b0;
            wr_data <= '0;
        end else begin
            wr_req <= word_done && !full_in;
            if (word_done && !full_in) begin
                wr_data <= word_in;
            end
        end
    end

    // R7: a request never lasts two cycles
    assert_wr_single_R7: assert property (@(posedge clk) disable iff (rst)
        wr_req |=> !wr_req);

endmodule

// File: rtl/ser_word_asm.sv
module ser_word_asm
    import ser_asm_pkg::*;
#(
    parameter int SLICES = 2
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        ser_in,
    input  logic                        cas_in,
    input  logic                        len_sel,
    input  logic                        full_in,
    output logic [SLICES-1:0]           tap8_o,
    output logic [SLICES-1:0]           tap9_o,
    output logic                        wr_req_o,
    output logic [SLICES*SLICE_W-1:0]   wr_data_o
);

    localparam int WORD_W = SLICES * SLICE_W;

    logic [SLICES-1:0] tap_sel;
    logic [SLICES-1:0] done_vec;
    logic [SLICES-1:0] cas_vec;
    logic [WORD_W-1:0] word_nxt;
    logic              end_tap;

    assign end_tap = tap_sel[SLICES-1];

    for (genvar k = 0; k < SLICES; k++) begin : g_slice
        slice_word_t w;

        if (k == 0) begin : g_head
            assign cas_vec[k] = cas_in;
        end else begin : g_chain
            assign cas_vec[k] = tap_sel[k-1];

            // R6: a later slice reaches its bit-8 marker only after its predecessor closed
            assert_cascade_order_R6: assert property (@(posedge clk) disable iff (rst)
                $rose(tap8_o[k]) |-> tap_sel[k-1]);
        end

        ser_slice #(.FIRST(k == 0)) i_slice (
            .clk      (clk),
            .rst      (rst),
            .ser_in   (ser_in),
            .cas_en   (cas_vec[k]),
            .len_sel  (len_sel),
            .restart  (end_tap),
            .tap8     (tap8_o[k]),
            .tap9     (tap9_o[k]),
            .tap_sel  (tap_sel[k]),
            .done_now (done_vec[k]),
            .word_nxt (w)
        );

        assign word_nxt[k*SLICE_W +: SLICE_W] = w;
    end

    ser_wr_port #(.SLICES(SLICES)) i_wr (
        .clk       (clk),
        .rst       (rst),
        .word_done (done_vec[SLICES-1]),
        .full_in   (full_in),
        .word_in   (word_nxt),
        .wr_req    (wr_req_o),
        .wr_data   (wr_data_o)
    );

    // R6: at most one slice closes on any edge
    assert_one_closer_R6: assert property (@(posedge clk) disable iff (rst)
        $onehot0(done_vec));

    // R7: a request coincides with the rise of the last slice's closing marker
    assert_wr_at_end_R7: assert property (@(posedge clk) disable iff (rst)
        wr_req_o |-> $rose(end_tap));

    // R8: a word completing under full is not written
    assert_full_drop_R8: assert property (@(posedge clk) disable iff (rst)
        ($rose(end_tap) && $past(full_in)) |-> !wr_req_o);

    // R2: the cycle after reset shows no markers and no request
    assert_reset_quiet_R2: assert property (@(posedge clk)
        $past(rst) |-> (tap8_o == '0 && tap9_o == '0 && !wr_req_o));

endmodule

// File: tb/test_ser_word_asm.sv
module test_ser_word_asm;

    localparam int SLICES = 2;
    localparam int WW     = SLICES * 9;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              ser_in = 1'b0;
    logic              cas_in = 1'b1;
    logic              len_sel = 1'b0;
    logic              full_in = 1'b0;
    logic [SLICES-1:0] tap8_o;
    logic [SLICES-1:0] tap9_o;
    logic              wr_req_o;
    logic [WW-1:0]     wr_data_o;

    int tests = 0;
    int fails = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    ser_word_asm #(.SLICES(SLICES)) i_ser_word_asm (
        .clk(clk), .rst(rst), .ser_in(ser_in), .cas_in(cas_in),
        .len_sel(len_sel), .full_in(full_in), .tap8_o(tap8_o), .tap9_o(tap9_o),
        .wr_req_o(wr_req_o), .wr_data_o(wr_data_o)
    );

    task automatic chk(input bit ok, input string req, input logic [WW-1:0] act,
                       input logic [WW-1:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick(input logic b);
        ser_in = b;
        @(posedge clk);
        #3;
    endtask

    task automatic do_reset(input logic nine);
        rst = 1'b1;
        len_sel = nine;
        tick(1'b0);
        tick(1'b0);
        rst = 1'b0;
    endtask

    function automatic logic [WW-1:0] pack(input logic [WW-1:0] s, input logic nine);
        logic [WW-1:0] d = '0;
        int w = nine ? 9 : 8;
        for (int k = 0; k < SLICES; k++)
            for (int p = 0; p < w; p++)
                d[k*9+p] = s[k*w+p];
        return d;
    endfunction

    // Sends one word; checks markers, the single request and the data
    task automatic send_word(input logic [WW-1:0] s, input logic nine, input logic expect_wr);
        int w = nine ? 9 : 8;
        int n = w * SLICES;
        int extra = 0;
        for (int i = 0; i < n; i++) begin
            tick(s[i]);
            if (i == 0)
                chk(tap8_o == '0 && tap9_o == '0, "R3 markers low on first edge",
                    WW'({tap9_o, tap8_o}), '0);
            if (i == 6)
                chk(tap8_o[0] == 1'b0, "R4 bit-8 marker early", WW'(tap8_o), 0);
            if (i == 7) begin
                chk(tap8_o[0] == 1'b1, "R4 bit-8 marker", WW'(tap8_o), 1);
                chk(tap9_o[0] == 1'b0, "R4 bit-9 marker early", WW'(tap9_o), 0);
            end
            if (i == w - 1)
                chk(tap8_o[1] == 1'b0, "R6 next slice waits", WW'(tap8_o), 1);
            if (nine && i == 8)
                chk(tap9_o[0] == 1'b1, "R5 bit-9 marker closes", WW'(tap9_o), 1);
            if (!nine && i == 8)
                chk(tap9_o[0] == 1'b0, "R5 no bit-9 marker in 8-bit mode", WW'(tap9_o), 0);
            if (i == w + 7)
                chk(tap8_o[1] == 1'b1, "R6 slice 1 bit-8 marker", WW'(tap8_o), 2'b11);
            if (i < n - 1 && wr_req_o) extra++;
        end
        chk(extra == 0, "R7 no early request", WW'(extra), 0);
        chk(wr_req_o == expect_wr, expect_wr ? "R7 request at completion" : "R8 full drops word",
            WW'(wr_req_o), WW'(expect_wr));
        if (expect_wr)
            chk(wr_data_o == pack(s, nine), nine ? "R1 R5 9-bit word" : "R1 R5 8-bit word",
                wr_data_o, pack(s, nine));
    endtask

    task automatic t_reset();
        rst = 1'b1;
        tick(1'b1);
        chk(tap8_o == '0 && tap9_o == '0 && !wr_req_o, "R2 reset state",
            WW'({wr_req_o, tap9_o, tap8_o}), '0);
        rst = 1'b0;
    endtask

    task automatic t_lsb_first();
        do_reset(1'b0);
        send_word(WW'(1), 1'b0, 1'b1);                 // R1 only bit 0 set
        send_word(WW'(18'h0A5C3), 1'b0, 1'b1);
        tick(1'b0);
        chk(!wr_req_o, "R7 pulse ends", WW'(wr_req_o), 0);
    endtask

    task automatic t_nine();
        do_reset(1'b1);
        send_word(WW'(18'h2B3D1), 1'b1, 1'b1);
        send_word(WW'(18'h3FFFF), 1'b1, 1'b1);
        send_word(WW'(18'h20001), 1'b1, 1'b1);
    endtask

    task automatic t_full();
        do_reset(1'b0);
        full_in = 1'b1;
        send_word(WW'(18'h0BEEF), 1'b0, 1'b0);         // R8 lost
        full_in = 1'b0;
        send_word(WW'(18'h01234), 1'b0, 1'b1);         // R8 next word normal
    endtask

    task automatic t_cas_idle();
        do_reset(1'b0);
        cas_in = 1'b0;
        for (int i = 0; i < 20; i++) tick(1'b1);
        chk(tap8_o == '0 && tap9_o == '0 && !wr_req_o, "R9 idle while disabled",
            WW'({wr_req_o, tap9_o, tap8_o}), '0);
        cas_in = 1'b1;
        send_word(WW'(18'h00F0F), 1'b0, 1'b1);         // R9 no leaked ones
    endtask

    initial begin
        #(200000 * 10);
        if (!finished) begin
            tests++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_lsb_first();
        t_nine();
        t_full();
        t_cas_idle();
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule